// File: doc/BRIEF.md
# Paged Segment Address Walker

This block turns a two-part segmented address (segment number, word offset) into a physical word address. Both the descriptor table and every data segment are stored in fixed 1024-word pages. The descriptor table therefore has to be translated before the data can be. The walker takes the low 10 bits of the segment number as the descriptor's word within a descriptor-table page and the upper bits as that page's number. It splits the offset the same way into a data page number and a word within the page.

A walk makes three dependent reads through one sequential memory read port. The first is a page-table entry of the descriptor table, taken from the descriptor-table base inputs. The second is the segment descriptor itself. The third is the page-table entry for the data page. The result is formed from that frame and the offset's word index. Any invalid entry, missing segment, bound violation or refused access type ends the walk with a fault that carries a cause code and the step that raised it. The caller holds the descriptor-table base: its page-table origin and its length in entries. A new request is accepted only while the walker is idle.

The states are IDLE, PT_DS (read the descriptor-table page entry), SDW (read the descriptor), PT_SEG (read the data page entry), DONE and FAULT. The transitions are:
- IDLE→PT_DS when a request is accepted.
- IDLE→FAULT when the segment number is out of the table bound.
- PT_DS→SDW when the entry is valid, PT_DS→FAULT when it is not.
- SDW→PT_SEG when the descriptor passes its checks, SDW→FAULT when it does not.
- PT_SEG→DONE when the entry is valid, PT_SEG→FAULT when it is not.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `pseg_walker`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, and mem_req, done_valid and fault_valid are 0.
- R2: A request is taken only on a cycle with req_ready high. req_valid pulses while a walk is running are ignored and change neither its reads nor its result.
- R3: A segment number greater than or equal to dbr_len faults with cause 2 and step 0. The fault appears in the cycle after acceptance and no memory read is made.
- R4: The first read is at dbr_pt_origin + (segment >> 10). A page-table entry is valid when bit 63 is set, and its bits [13:0] hold the frame number. An invalid entry faults with cause 1 and step 1.
- R5: The second read is at {frame, segment[9:0]}. Descriptor fields: bits [23:0] are the page-table origin of the segment, [47:24] its length in words, bit 48 read permit, bit 49 write permit, bit 50 execute permit, and bit 51 the missing flag.
- R6: A descriptor with the missing flag set faults with cause 3 and step 2. This takes priority over the bound and access checks.
- R7: An offset greater than or equal to the descriptor length faults with cause 4 and step 2, and no third read is made.
- R8: req_acc has bit 0 for read, bit 1 for write and bit 2 for execute. If any requested bit is not permitted by the descriptor, the walk faults with cause 5 and step 2. Bound takes priority over access.
- R9: The third read is at descriptor origin + (offset >> 10). An invalid entry faults with cause 6 and step 3.
- R10: A successful walk makes exactly three reads. It raises done_valid for one cycle with done_paddr = {frame, offset[9:0]}.
- R11: mem_req is high for exactly one cycle per read. The walker waits for mem_rvalid before the next step, whatever the read latency.
- R12: fault_valid is high for exactly one cycle with a cause in 1..6. The walker is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbr_pt_origin | input | PADDR_W | Word address of the descriptor table's page table |
| dbr_len | input | SEG_W+1 | Descriptor table length in entries |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High while idle; a request is taken on such a cycle |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | OFS_W | Word offset within the segment |
| req_acc | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| mem_req | output | 1 | Read request, one cycle per read |
| mem_addr | output | PADDR_W | Read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done_valid | output | 1 | One-cycle pulse for a completed walk |
| done_paddr | output | PADDR_W | Translated physical word address |
| fault_valid | output | 1 | One-cycle pulse for a faulted walk |
| fault_cause | output | 3 | 1 descriptor page invalid, 2 table bound, 3 segment missing, 4 segment bound, 5 access denied, 6 data page invalid |
| fault_step | output | 2 | Step that faulted: 0 before any read, 1 to 3 the read number |

## Verification
On every cycle the assertions check the handshake and pulse rules. They check that the walker is ready only with no read, result or fault pending, and that each read request lasts one cycle. They check that done and fault are exclusive one-cycle pulses followed by idle, that every fault cause is legal, that an out-of-bound segment faults at once, and that the result keeps the offset's word index. The bench scenarios show the things that depend on table contents. These are the exact read addresses in each step, the frame chosen for the result, the order of priority among the descriptor faults, ignored requests during a walk, and correct waiting under a longer read latency.

// File: rtl/pseg_pkg.sv
package pseg_pkg;
    localparam int PAGE_W  = 10;
    localparam int DATA_W  = 64;
    localparam int PTE_VLD = 63;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_DS_PAGE   = 3'd1,
        FC_TBL_BOUND = 3'd2,
        FC_SEG_MISS  = 3'd3,
        FC_SEG_BOUND = 3'd4,
        FC_ACCESS    = 3'd5,
        FC_DATA_PAGE = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PT_DS, ST_SDW, ST_PT_SEG, ST_DONE, ST_FAULT
    } state_e;

    typedef struct packed {
        logic        missing;
        logic [2:0]  perm;
        logic [23:0] len;
        logic [23:0] org;
    } sdw_t;

    function automatic sdw_t unpack_sdw(input logic [DATA_W-1:0] w);
        return sdw_t'(w[51:0]);
    endfunction
endpackage

// File: rtl/pseg_split.sv
module pseg_split
    import pseg_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0]        idx,
    output logic [IDX_W-PAGE_W-1:0] page,
    output logic [PAGE_W-1:0]       word
);
    assign page = idx[IDX_W-1:PAGE_W];
    assign word = idx[PAGE_W-1:0];
endmodule

// File: rtl/pseg_pte_decode.sv
module pseg_pte_decode
    import pseg_pkg::*;
#(
    parameter int FRAME_W = 14
) (
    input  logic [DATA_W-1:0]  entry,
    output logic               valid,
    output logic [FRAME_W-1:0] frame
);
    assign valid = entry[PTE_VLD];
    assign frame = entry[FRAME_W-1:0];
endmodule

// File: rtl/pseg_sdw_check.sv
module pseg_sdw_check
    import pseg_pkg::*;
#(
    parameter int OFS_W   = 18,
    parameter int PADDR_W = 24
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [2:0]         acc,
    output logic               hit,
    output fault_e             cause,
    output logic [PADDR_W-1:0] pt_org
);
    sdw_t d;
    logic over_len;
    logic denied;

    assign d        = unpack_sdw(word);
    assign over_len = 24'(ofs) >= d.len;
    assign denied   = (acc & ~d.perm) != 3'b000;
    assign pt_org   = PADDR_W'(d.org);

    always_comb begin
        hit   = 1'b1;
        cause = FC_NONE;
        if (d.missing)     cause = FC_SEG_MISS;
        else if (over_len) cause = FC_SEG_BOUND;
        else if (denied)   cause = FC_ACCESS;
        else               hit   = 1'b0;
    end
endmodule

// File: rtl/pseg_walk_fsm.sv
module pseg_walk_fsm
    import pseg_pkg::*;
#(
    parameter int SEG_W   = 12,
    parameter int OFS_W   = 18,
    parameter int PADDR_W = 24,
    localparam int FRAME_W = PADDR_W - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PADDR_W-1:0] dbr_pt_origin,
    input  logic [SEG_W:0]     dbr_len,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [2:0]         req_acc,
    output logic               mem_req,
    output logic [PADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic               pte_valid,
    input  logic [FRAME_W-1:0] pte_frame,
    input  logic               sdw_hit,
    input  fault_e             sdw_cause,
    input  logic [PADDR_W-1:0] sdw_pt_org,
    output logic [OFS_W-1:0]   ofs_cur,
    output logic [2:0]         acc_cur,
    output logic               done_valid,
    output logic [PADDR_W-1:0] done_paddr,
    output logic               fault_valid,
    output logic [2:0]         fault_cause,
    output logic [1:0]         fault_step
);
    state_e state_q, state_d;

    logic [SEG_W-1:0]   seg_q;
    logic [OFS_W-1:0]   ofs_q;
    logic [2:0]         acc_q;
    logic [PADDR_W-1:0] dorg_q;
    logic [PADDR_W-1:0] sorg_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PADDR_W-1:0] paddr_q;
    fault_e             cause_q;
    logic [1:0]         step_q;
    logic               wait_q;

    logic [SEG_W-PAGE_W-1:0] seg_pg;
    logic [PAGE_W-1:0]       seg_wd;
    logic [OFS_W-PAGE_W-1:0] ofs_pg;
    logic [PAGE_W-1:0]       ofs_wd;

    pseg_split #(.IDX_W(SEG_W)) u_seg_split (.idx(seg_q), .page(seg_pg), .word(seg_wd));
    pseg_split #(.IDX_W(OFS_W)) u_ofs_split (.idx(ofs_q), .page(ofs_pg), .word(ofs_wd));

    logic accept;
    logic out_of_table;
    logic resp;

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign out_of_table = {1'b0, req_seg} >= dbr_len;
    assign resp         = wait_q && mem_rvalid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = out_of_table ? ST_FAULT : ST_PT_DS;
            ST_PT_DS:  if (resp) state_d = pte_valid ? ST_SDW : ST_FAULT;
            ST_SDW:    if (resp) state_d = sdw_hit ? ST_FAULT : ST_PT_SEG;
            ST_PT_SEG: if (resp) state_d = pte_valid ? ST_DONE : ST_FAULT;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q   <= '0;
            ofs_q   <= '0;
            acc_q   <= '0;
            dorg_q  <= '0;
            sorg_q  <= '0;
            frame_q <= '0;
            paddr_q <= '0;
            cause_q <= FC_NONE;
            step_q  <= '0;
            wait_q  <= 1'b0;
        end else begin
            if (mem_req) wait_q <= 1'b1;
            else if (resp) wait_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    seg_q  <= req_seg;
                    ofs_q  <= req_ofs;
                    acc_q  <= req_acc;
                    dorg_q <= dbr_pt_origin;
                    if (out_of_table) begin
                        cause_q <= FC_TBL_BOUND;
                        step_q  <= 2'd0;
                    end
                end
                ST_PT_DS: if (resp) begin
                    frame_q <= pte_frame;
                    if (!pte_valid) begin
                        cause_q <= FC_DS_PAGE;
                        step_q  <= 2'd1;
                    end
                end
                ST_SDW: if (resp) begin
                    sorg_q <= sdw_pt_org;
                    if (sdw_hit) begin
                        cause_q <= sdw_cause;
                        step_q  <= 2'd2;
                    end
                end
                ST_PT_SEG: if (resp) begin
                    if (pte_valid) paddr_q <= {pte_frame, ofs_wd};
                    else begin
                        cause_q <= FC_DATA_PAGE;
                        step_q  <= 2'd3;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        done_valid  = (state_q == ST_DONE);
        fault_valid = (state_q == ST_FAULT);
        mem_req     = 1'b0;
        mem_addr    = '0;
        unique case (state_q)
            ST_PT_DS: begin
                mem_req  = !wait_q;
                mem_addr = dorg_q + PADDR_W'(seg_pg);
            end
            ST_SDW: begin
                mem_req  = !wait_q;
                mem_addr = {frame_q, seg_wd};
            end
            ST_PT_SEG: begin
                mem_req  = !wait_q;
                mem_addr = sorg_q + PADDR_W'(ofs_pg);
            end
            default: ;
        endcase
    end

    assign done_paddr  = paddr_q;
    assign fault_cause = cause_q;
    assign fault_step  = step_q;
    assign ofs_cur     = ofs_q;
    assign acc_cur     = acc_q;
endmodule

// File: rtl/pseg_walker.sv
module pseg_walker
    import pseg_pkg::*;
#(
    parameter int SEG_W   = 12,
    parameter int OFS_W   = 18,
    parameter int PADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PADDR_W-1:0] dbr_pt_origin,
    input  logic [SEG_W:0]     dbr_len,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [2:0]         req_acc,
    output logic               mem_req,
    output logic [PADDR_W-1:0] mem_addr,
    input  logic               mem_rvalid,
    input  logic [63:0]        mem_rdata,
    output logic               done_valid,
    output logic [PADDR_W-1:0] done_paddr,
    output logic               fault_valid,
    output logic [2:0]         fault_cause,
    output logic [1:0]         fault_step
);
    localparam int FRAME_W = PADDR_W - PAGE_W;

    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;
    logic               sdw_hit;
    fault_e             sdw_cause;
    logic [PADDR_W-1:0] sdw_pt_org;
    logic [OFS_W-1:0]   ofs_cur;
    logic [2:0]         acc_cur;

    pseg_pte_decode #(.FRAME_W(FRAME_W)) u_pte (
        .entry(mem_rdata), .valid(pte_valid), .frame(pte_frame)
    );

    pseg_sdw_check #(.OFS_W(OFS_W), .PADDR_W(PADDR_W)) u_sdw (
        .word(mem_rdata), .ofs(ofs_cur), .acc(acc_cur),
        .hit(sdw_hit), .cause(sdw_cause), .pt_org(sdw_pt_org)
    );

    pseg_walk_fsm #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PADDR_W(PADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .dbr_pt_origin(dbr_pt_origin), .dbr_len(dbr_len),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_ofs(req_ofs), .req_acc(req_acc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .pte_valid(pte_valid), .pte_frame(pte_frame),
        .sdw_hit(sdw_hit), .sdw_cause(sdw_cause), .sdw_pt_org(sdw_pt_org),
        .ofs_cur(ofs_cur), .acc_cur(acc_cur),
        .done_valid(done_valid), .done_paddr(done_paddr),
        .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_step(fault_step)
    );
endmodule

// File: rtl/pseg_walker_chk.sv
module pseg_walker_chk #(
    parameter int SEG_W   = 12,
    parameter int OFS_W   = 18,
    parameter int PADDR_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SEG_W:0]     dbr_len,
    input logic               req_valid,
    input logic               req_ready,
    input logic [SEG_W-1:0]   req_seg,
    input logic [OFS_W-1:0]   req_ofs,
    input logic               mem_req,
    input logic               done_valid,
    input logic [PADDR_W-1:0] done_paddr,
    input logic               fault_valid,
    input logic [2:0]         fault_cause,
    input logic [1:0]         fault_step
);
    logic [9:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (req_valid && req_ready) word_q <= req_ofs[9:0];
    end

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done_valid && !fault_valid));

    a_r11_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    a_r10_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_paddr[9:0] == word_q));

    a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && req_ready));

    a_r12_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause >= 3'd1 && fault_cause <= 3'd6 && !done_valid));

    a_r3_bound_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= dbr_len))
        |=> (fault_valid && fault_cause == 3'd2 && fault_step == 2'd0));
endmodule

bind pseg_walker pseg_walker_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PADDR_W(PADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dbr_len(dbr_len),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_ofs(req_ofs), .mem_req(mem_req),
    .done_valid(done_valid), .done_paddr(done_paddr),
    .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_step(fault_step)
);

// File: tb/sim_pseg_walker.sv
`timescale 1ns/1ps
module sim_pseg_walker;
    localparam int SEG_W = 12, OFS_W = 18, PADDR_W = 24;

    logic clk = 0, rst_n = 0;
    logic [PADDR_W-1:0] dbr_pt_origin = 24'h001000;
    logic [SEG_W:0]     dbr_len = 13'd3000;
    logic req_valid = 0, req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFS_W-1:0] req_ofs = '0;
    logic [2:0] req_acc = '0;
    logic mem_req, mem_rvalid = 0;
    logic [PADDR_W-1:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic done_valid, fault_valid;
    logic [PADDR_W-1:0] done_paddr;
    logic [2:0] fault_cause;
    logic [1:0] fault_step;

    always #2.5 clk = ~clk;

    pseg_walker #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PADDR_W(PADDR_W)) u0 (.*);

    // memory model
    logic [63:0] mem [int unsigned];
    int mem_lat = 1;
    int rd_cnt = 0;
    logic [PADDR_W-1:0] rd_log [0:255];
    logic busy = 0;
    int cnt = 0;
    logic [PADDR_W-1:0] pend_addr;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            rd_log[rd_cnt[7:0]] <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
            busy      <= 1'b1;
            cnt       <= mem_lat;
            pend_addr <= mem_addr;
        end else if (busy) begin
            if (cnt <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(int'(pend_addr)) ? mem[int'(pend_addr)] : 64'd0;
                busy       <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pte(input bit v, input int frame);
        return {v, 49'd0, 14'(frame)};
    endfunction
    function automatic logic [63:0] sdw(input bit miss, input logic [2:0] perm, input int len, input int org);
        return {12'd0, miss, perm, 24'(len), 24'(org)};
    endfunction

    // walk results
    int res_cycles, res_reads, res_base;
    logic res_done, res_fault;
    logic [PADDR_W-1:0] res_paddr;
    logic [2:0] res_cause;
    logic [1:0] res_step;

    task automatic walk(input int seg, input int ofs, input logic [2:0] acc, input bit poke_busy);
        @(negedge clk);
        req_valid = 1; req_seg = SEG_W'(seg); req_ofs = OFS_W'(ofs); req_acc = acc;
        while (!req_ready) @(negedge clk);
        res_base = rd_cnt;
        @(negedge clk);
        req_valid = 0;
        res_cycles = 0;
        while (!done_valid && !fault_valid && res_cycles < 100) begin
            if (poke_busy && res_cycles == 1) begin
                req_valid = 1; req_seg = 12'd1030; req_ofs = 18'd5; req_acc = 3'b100;
            end else req_valid = 0;
            @(negedge clk);
            res_cycles++;
        end
        req_valid = 0;
        res_done = done_valid; res_fault = fault_valid;
        res_paddr = done_paddr; res_cause = fault_cause; res_step = fault_step;
        res_reads = rd_cnt - res_base;
    endtask

    task automatic expect_fault(input string req, input int cause, input int step, input int reads);
        check({req, " fault"}, res_fault, 1);
        check({req, " cause"}, res_cause, cause);
        check({req, " step"}, res_step, step);
        check({req, " reads"}, res_reads, reads);
    endtask

    task automatic t_reset;
        check("R1 ready", req_ready, 1);
        check("R1 mem_req", mem_req, 0);
        check("R1 done", done_valid, 0);
        check("R1 fault", fault_valid, 0);
    endtask

    task automatic t_success;
        walk(5, 3000, 3'b001, 0);
        check("R10 done", res_done, 1);
        check("R10 paddr", res_paddr, (24'h155 << 10) | 952);
        check("R10 three reads", res_reads, 3);
        check("R4 read1 addr", rd_log[res_base[7:0]], 24'h001000);
        check("R5 read2 addr", rd_log[8'(res_base + 1)], (24'h020 << 10) | 5);
        check("R9 read3 addr", rd_log[8'(res_base + 2)], 24'h003002);
        @(negedge clk);
        check("R10 done one cycle", done_valid, 0);
        check("R10 idle after", req_ready, 1);
    endtask

    task automatic t_second_page;
        walk(1030, 1023, 3'b100, 0);
        check("R5 seg page1 done", res_done, 1);
        check("R5 seg page1 paddr", res_paddr, (24'h2AA << 10) | 1023);
        check("R4 read1 page1", rd_log[res_base[7:0]], 24'h001001);
        check("R5 read2 page1", rd_log[8'(res_base + 1)], (24'h021 << 10) | 6);
    endtask

    task automatic t_faults;
        walk(3000, 0, 3'b001, 0);
        expect_fault("R3", 2, 0, 0);
        check("R3 immediate", res_cycles, 0);
        @(negedge clk);
        check("R12 fault one cycle", fault_valid, 0);
        check("R12 idle after", req_ready, 1);
        walk(2050, 0, 3'b001, 0);
        expect_fault("R4", 1, 1, 1);
        walk(7, 0, 3'b001, 0);
        expect_fault("R6", 3, 2, 2);
        walk(1030, 1024, 3'b100, 0);
        expect_fault("R7", 4, 2, 2);
        walk(1030, 1024, 3'b001, 0);
        check("R8 bound over access", res_cause, 4);
        walk(1030, 10, 3'b001, 0);
        expect_fault("R8", 5, 2, 2);
        walk(5, 10, 3'b011, 0);
        check("R8 read+write permitted", res_done, 1);
        walk(5, 10, 3'b110, 0);
        expect_fault("R8 write+exec", 5, 2, 2);
        walk(8, 2000, 3'b001, 0);
        expect_fault("R9", 6, 3, 3);
        check("R9 read3 addr", rd_log[8'(res_base + 2)], 24'h003201);
    endtask

    task automatic t_busy_ignore;
        walk(5, 100, 3'b001, 1);
        check("R2 result kept", res_paddr, (24'h150 << 10) | 100);
        check("R2 reads kept", res_reads, 3);
        @(negedge clk);
        check("R2 no extra walk", mem_req, 0);
        check("R2 ready", req_ready, 1);
    endtask

    task automatic t_latency;
        mem_lat = 5;
        walk(5, 3000, 3'b001, 0);
        check("R11 slow paddr", res_paddr, (24'h155 << 10) | 952);
        check("R11 slow reads", res_reads, 3);
        check("R11 slow waited", res_cycles >= 15, 1);
        mem_lat = 1;
    endtask

    initial begin
        mem[32'h1000] = pte(1, 24'h020);
        mem[32'h1001] = pte(1, 24'h021);
        mem[32'h1002] = pte(0, 24'h022);
        mem[(32'h020 << 10) | 5] = sdw(0, 3'b011, 5000, 24'h003000);
        mem[(32'h020 << 10) | 7] = sdw(1, 3'b111, 0, 24'h003300);
        mem[(32'h020 << 10) | 8] = sdw(0, 3'b001, 4096, 24'h003200);
        mem[(32'h021 << 10) | 6] = sdw(0, 3'b100, 1024, 24'h003100);
        mem[32'h3000] = pte(1, 24'h150);
        mem[32'h3002] = pte(1, 24'h155);
        mem[32'h3100] = pte(1, 24'h2AA);
        mem[32'h3200] = pte(1, 24'h160);
        mem[32'h3201] = pte(0, 24'h161);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_success();
        t_second_page();
        t_faults();
        t_busy_ignore();
        t_latency();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule